// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer peripheral. It holds a parameterised number of independent down-counters, four by default, and a shared interrupt controller. Each counter steps down once for every qualifying pulse on the tick input. Software starts a counter by writing a start value, and can reach it at any time through a synchronous register bus. When a counter reaches zero it raises its own interrupt bit. It then either reloads and keeps running (periodic mode) or parks at zero (one-shot mode).

Each channel is run by a small state machine with three states:

- `CH_IDLE`: the count is held.
- `CH_RUN`: the count steps down on qualified ticks.
- `CH_DONE`: a one-shot channel has expired and sits at zero.

The transitions between the states are:

| Transition | Condition |
|---|---|
| enable (IDLE→RUN) | the enable bit is set |
| disable (RUN→IDLE) | the enable bit is cleared |
| expire (RUN→DONE) | a one-shot step reaches zero |
| restart (any→RUN) | a start-value write while the enable bit is set |
| park (any→IDLE) | a start-value write while the enable bit is clear |

The state `CH_DONE` ignores the enable bit. Only a start-value write moves a channel out of it.

Addresses are byte addresses; bits [1:0] are ignored. Channel n occupies page n (address bits [7:4] = n), with these word offsets:

| Offset | Register | Access |
|---|---|---|
| 0x0 | start value | write |
| 0x4 | reload value | read/write |
| 0x8 | control | read/write |
| 0xC | current count | read only |

The interrupt page follows the last channel page, at 0x40 by default, with these word offsets:

| Offset | Register | Access |
|---|---|---|
| 0x0 | enable mask | read/write |
| 0x4 | raw status | read only |
| 0x8 | masked status | read only |
| 0xC | clear | write only |

Top module: `multi_timer`

## Requirements
- R1: An enabled channel in divide-by-1 mode decrements its count by one at every clock edge where `tick_in` is high. The count is readable at channel offset 0xC.
- R2: When control bit 2 is 1, the channel steps once per 16 ticks. The first step comes on the 16th tick after enabling or after a start-value write.
- R3: Control bit 0 enables counting. While it is 0, ticks leave the count unchanged.
- R4: A write to channel offset 0x0 replaces the count at that clock edge, with no wait for the current period to end. The same write also sets the reload value.
- R5: A write to channel offset 0x4 changes only the reload value. The running count is not disturbed.
- R6: With control bit 1 at 0 (periodic mode), a step that brings the count to zero loads the reload value instead and sets raw status bit n.
- R7: With control bit 1 at 1 (one-shot mode), a step that brings the count to zero sets raw bit n. The count then stays at zero, whatever the ticks, until the next start-value write.
- R8: A start value of zero gives the longest interval: the first step wraps the count to all ones, and no interrupt is raised.
- R9: Control bit 3 selects the counter width: 1 is 32-bit and 0 is 16-bit. In 16-bit mode a start value is truncated to its low 16 bits, and counting wraps at 16 bits.
- R10: Interrupt mask bit n enables channel n. `irq_o` is the OR over all channels of raw AND mask. The masked status is readable at interrupt offset 0x8.
- R11: Writing 1 to bit n of interrupt offset 0xC clears raw bit n, and writing 0 leaves it unchanged. A new zero event in the same cycle wins over the clear.
- R12: After reset all counts, reload values, control bits, mask and raw status are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Counting tick strobe |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the points where timers usually go wrong.

- **Start-value write while running.** It must cut the period short. A design that waited for the reload would still show the old count.
- **Reload-value write while running.** A design that copied it into the count would skip ahead.
- **Periodic versus one-shot at zero.** A periodic channel must reload. A one-shot channel that kept counting would wrap to all ones.
- **Zero start value.** A design that treated zero as an immediate expiry would raise an interrupt.
- **16-bit width.** A design that ignored the width bit would read back 32-bit values.
- **Divide-by-16 phase.** A design that stepped on the first tick would be off by one count.
- **Clear with a zero bit.** Writing 0 must not drop a pending interrupt.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    // control register bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_ONE   = 1;
    localparam int CTL_DIV16 = 2;
    localparam int CTL_WIDE  = 3;
    localparam int CTL_W     = 4;

    // word offsets inside a page (address bits [3:2])
    localparam logic [1:0] OFS_START  = 2'd0;
    localparam logic [1:0] OFS_RELOAD = 2'd1;
    localparam logic [1:0] OFS_CTRL   = 2'd2;
    localparam logic [1:0] OFS_COUNT  = 2'd3;

    localparam logic [1:0] OFS_MASK   = 2'd0;
    localparam logic [1:0] OFS_RAW    = 2'd1;
    localparam logic [1:0] OFS_MSTAT  = 2'd2;
    localparam logic [1:0] OFS_CLEAR  = 2'd3;

    typedef struct packed {
        logic wide;
        logic div16;
        logic oneshot;
        logic en;
    } ch_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    input  logic div_en,
    output logic step
);
    localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || restart) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    always_comb begin
        step = run && tick && !restart && (!div_en || pre_cnt == LAST);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_we,
    input  logic             reload_we,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output ch_ctrl_t         ctrl,
    output logic             zero_evt
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] FULL_MASK = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HALF_MASK = {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    ch_state_e        state, state_nx;
    logic             step;
    logic [CNT_W-1:0] wmask;
    logic [CNT_W-1:0] dec_cnt;
    logic             hits_zero;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == CH_RUN),
        .restart (start_we),
        .tick    (tick),
        .div_en  (ctrl.div16),
        .step    (step)
    );

    always_comb begin
        wmask     = ctrl.wide ? FULL_MASK : HALF_MASK;
        dec_cnt   = (count - 1'b1) & wmask;
        hits_zero = (dec_cnt == '0);
        zero_evt  = step && hits_zero;
    end

    // control and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            reload <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl <= ch_ctrl_t'(wdata[CTL_W-1:0]);
            end
            if (start_we || reload_we) begin
                reload <= wdata;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_we) begin
            state_nx = ctrl.en ? CH_RUN : CH_IDLE;
        end else begin
            unique case (state)
                CH_IDLE: if (ctrl.en) state_nx = CH_RUN;
                CH_RUN: begin
                    if (!ctrl.en) begin
                        state_nx = CH_IDLE;
                    end else if (step && hits_zero && ctrl.oneshot) begin
                        state_nx = CH_DONE;
                    end
                end
                CH_DONE: state_nx = CH_DONE;
                default: state_nx = CH_IDLE;
            endcase
        end
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start_we) begin
            count <= wdata & wmask;
        end else if (step) begin
            if (hits_zero && !ctrl.oneshot) begin
                count <= reload & wmask;
            end else begin
                count <= dec_cnt;
            end
        end
    end

    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && !start_we) |=> $stable(count));

    assert_load_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_we |=> count == ($past(wdata) & $past(wmask)));

    assert_reload_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_we && !start_we && !step) |=> $stable(count));

    assert_oneshot_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && !start_we) |=> (count == $past(count)) && (state == CH_DONE));

    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_we || step) && !ctrl.wide) |=> (count & ~HALF_MASK) == '0);

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] mstat,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_we ? wbits : '0;
        mstat    = raw & mask;
        irq      = |mstat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | evt;
            if (mask_we) begin
                mask <= wbits;
            end
        end
    end

    assert_raw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~evt)) |=> ((raw & $past(clr_bits & ~evt)) == '0));

    assert_clear_zero_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw & $past(raw & ~clr_bits)) == $past(raw & ~clr_bits)));

endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int PAGE_W = ADDR_W - 4;
    localparam logic [PAGE_W-1:0] IRQ_PAGE = PAGE_W'(NUM_CH);

    logic [PAGE_W-1:0] page;
    logic [1:0]        ofs;

    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [CNT_W-1:0]  ch_reload [NUM_CH];
    ch_ctrl_t          ch_ctrl   [NUM_CH];
    logic [NUM_CH-1:0] zero_evt;

    logic [NUM_CH-1:0] irq_raw, irq_mask, irq_mstat;
    logic              irq_page_we;

    always_comb begin
        page        = bus_addr[ADDR_W-1:4];
        ofs         = bus_addr[3:2];
        irq_page_we = bus_we && (page == IRQ_PAGE);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic page_hit;
        always_comb page_hit = bus_we && (page == PAGE_W'(i));

        tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_in),
            .start_we  (page_hit && ofs == OFS_START),
            .reload_we (page_hit && ofs == OFS_RELOAD),
            .ctrl_we   (page_hit && ofs == OFS_CTRL),
            .wdata     (bus_wdata),
            .count     (ch_count[i]),
            .reload    (ch_reload[i]),
            .ctrl      (ch_ctrl[i]),
            .zero_evt  (zero_evt[i])
        );
    end

    tmr_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (zero_evt),
        .mask_we (irq_page_we && ofs == OFS_MASK),
        .clr_we  (irq_page_we && ofs == OFS_CLEAR),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .raw     (irq_raw),
        .mask    (irq_mask),
        .mstat   (irq_mstat),
        .irq     (irq_o)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (page == IRQ_PAGE) begin
            unique case (ofs)
                OFS_MASK:  bus_rdata = CNT_W'(irq_mask);
                OFS_RAW:   bus_rdata = CNT_W'(irq_raw);
                OFS_MSTAT: bus_rdata = CNT_W'(irq_mstat);
                default:   bus_rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (page == PAGE_W'(i)) begin
                    unique case (ofs)
                        OFS_RELOAD: bus_rdata = ch_reload[i];
                        OFS_CTRL:   bus_rdata = CNT_W'(ch_ctrl[i]);
                        OFS_COUNT:  bus_rdata = ch_count[i];
                        default:    bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq_o);

endmodule

// File: tb/tb_multi_timer.sv
module tb_multi_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    multi_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    localparam logic [7:0] A_MASK = 8'h40, A_RAW = 8'h44, A_MST = 8'h48, A_CLR = 8'h4C;

    function automatic logic [7:0] ca(input int ch, input int ofs);
        return 8'(ch * 16 + ofs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_in = 1'b1;
        end
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ca(0, 12), v); chk("R12 count0", v, 0);
        rd(ca(2, 8), v);  chk("R12 ctrl2", v, 0);
        rd(A_RAW, v);     chk("R12 raw", v, 0);
        chk("R12 irq", 32'(irq_o), 0);
    endtask

    task automatic t_count_enable();
        logic [31:0] v;
        wr(ca(0, 0), 100);
        rd(ca(0, 12), v); chk("R4 start write", v, 100);
        wr(ca(0, 8), 32'h9);
        ticks(5);
        rd(ca(0, 12), v); chk("R1 decrement", v, 95);
        wr(ca(0, 8), 32'h8);
        ticks(5);
        rd(ca(0, 12), v); chk("R3 disabled hold", v, 95);
    endtask

    task automatic t_periodic_irq();
        logic [31:0] v;
        wr(ca(0, 8), 32'h9);
        ticks(2);
        wr(ca(0, 0), 10);
        rd(ca(0, 12), v); chk("R4 replace running", v, 10);
        wr(ca(0, 4), 3);
        rd(ca(0, 12), v); chk("R5 reload no disturb", v, 10);
        ticks(10);
        rd(ca(0, 12), v); chk("R6 periodic reload", v, 3);
        rd(A_RAW, v);     chk("R6 raw set", v, 1);
        chk("R10 masked low", 32'(irq_o), 0);
        wr(A_MASK, 1);
        chk("R10 irq high", 32'(irq_o), 1);
        rd(A_MST, v);     chk("R10 masked status", v, 1);
        wr(A_CLR, 0);
        rd(A_RAW, v);     chk("R11 zero no effect", v, 1);
        wr(ca(0, 8), 32'h8);
        wr(A_CLR, 1);
        rd(A_RAW, v);     chk("R11 clear", v, 0);
        chk("R11 irq low", 32'(irq_o), 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(ca(1, 0), 4);
        wr(ca(1, 8), 32'hB);
        ticks(4);
        rd(ca(1, 12), v); chk("R7 expire", v, 0);
        rd(A_RAW, v);     chk("R7 raw bit1", v, 2);
        ticks(5);
        rd(ca(1, 12), v); chk("R7 rest at zero", v, 0);
        wr(ca(1, 0), 2);
        ticks(1);
        rd(ca(1, 12), v); chk("R7 restart", v, 1);
        ticks(1);
        rd(ca(1, 12), v); chk("R7 second expiry", v, 0);
        wr(A_CLR, 2);
    endtask

    task automatic t_zero_wrap();
        logic [31:0] v;
        wr(ca(2, 8), 32'h9);
        wr(ca(2, 0), 0);
        ticks(1);
        rd(ca(2, 12), v); chk("R8 wrap", v, 32'hFFFF_FFFF);
        rd(A_RAW, v);     chk("R8 no irq", v, 0);
        wr(ca(2, 8), 32'h8);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        wr(ca(3, 8), 32'h1);
        wr(ca(3, 0), 0);
        ticks(1);
        rd(ca(3, 12), v); chk("R9 16-bit wrap", v, 32'h0000_FFFF);
        wr(ca(3, 0), 32'h0001_2345);
        rd(ca(3, 12), v); chk("R9 truncate", v, 32'h0000_2345);
        wr(ca(3, 8), 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(ca(0, 8), 32'hD);
        wr(ca(0, 0), 50);
        ticks(15);
        rd(ca(0, 12), v); chk("R2 no step before 16", v, 50);
        ticks(1);
        rd(ca(0, 12), v); chk("R2 step at 16", v, 49);
        ticks(32);
        rd(ca(0, 12), v); chk("R2 two more steps", v, 47);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_enable();
        t_periodic_irq();
        t_oneshot();
        t_zero_wrap();
        t_narrow();
        t_prescale();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule